// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block issues one complete command sequence to a small-page NAND flash over an asynchronous latch bus. The host hands over a request made of a command byte, a column, a page address, valid flags for the column and the page, and two mode flags: a 16-bit bus flag and a large-device flag. The sequencer then drives the command-latch and address-latch cycles with a write strobe. Depending on the command, it either finishes at once or waits for the device's ready line. A single-cycle done pulse marks the end of each sequence. Data transfer, ECC and bad-block handling belong to other blocks.

A data-input command is always preceded by a read-pointer command. The sequencer picks that pointer command from the column region and rebases the column to match. For read commands that carry a page address, chip enable is held low from the first page byte until the device is ready, so that the bus cannot be handed to another device during the busy time. Bus timing comes from parameters: the strobe width in clock cycles, the clock period, the tWB delay and the read timeout.

The state machine has seven states:
- IDLE accepts a request. It moves to PRE_CMD when the command is data-input, and to CMD otherwise.
- PRE_CMD sends the pointer byte and moves to CMD.
- CMD sends the command byte. It moves to ADDR when any address field is present, and otherwise to the post-phase choice.
- ADDR sends each address byte in turn.
- The post-phase choice after the last byte is DONE for no-wait commands and TWB for all other commands.
- TWB waits out the tWB delay and moves to WAIT.
- WAIT moves to DONE when ready is seen, or when the read timeout expires.
- DONE moves to IDLE.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only in IDLE, and a request is taken when `req_valid` and `req_ready` are both high. Requests offered while the block is busy are ignored. `seq_done` is high for exactly one cycle, and `req_ready` is high again in the cycle that follows.
- R2: Each bus byte lasts 2*WE_CYC cycles. `nand_we_n` is low for the first WE_CYC of them and high for the rest. `nand_dq` carries {8'h00, byte} throughout the byte. `nand_cle` is high for command bytes and `nand_ale` is high for address bytes. Outside bytes, `nand_dq` is zero and `nand_we_n` is high.
- R3: A data-input command (0x80) is preceded by a pointer byte chosen from the column:
  - A column at or above PAGE_BYTES (512) gives 0x50, and the column is reduced by 512.
  - A column below 256 gives 0x00.
  - Any other column gives 0x01, and the column is reduced by 256.
- R4: Address bytes are sent only when the column or the page is flagged valid. `nand_ale` falls after the last address byte.
- R5: The column byte, when present, comes first. It is the low 8 bits of the (adjusted) column, shifted right by one when `req_bus16` is set.
- R6: The page address follows the column as page[7:0] and then page[15:8]. When `req_big` is set, a third byte {4'h0, page[19:16]} follows.
- R7: `nand_ce_n` is low during every byte and high in IDLE and DONE. For the reads 0x00, 0x01 and 0x50 with a page present, it also stays low from the end of the first page byte through the whole wait.
- R8: The commands 0x10, 0x60, 0xD0, 0x80 and 0x70 pulse done in the cycle right after their last byte, without looking at ready.
- R9: All other commands spend TWB_CYC = ceil(100 ns / clock period) cycles before ready is sampled.
- R10: `nand_rdy` passes through two flops. Ready driven high before clock edge k ends the wait no earlier than the cycle after edge k+1.
- R11: The ready wait for the reads 0x00, 0x01 and 0x50 lasts at most TOUT_CYC = ceil(30 us / clock period) cycles. For every other waiting command, including reset (0xFF), the wait has no bound.
- R12: After reset the outputs are idle: CLE and ALE low, `nand_we_n` and `nand_ce_n` high, `nand_dq` zero, done low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_cmd | input | 8 | Command byte |
| req_col | input | COL_W | Column address |
| req_col_vld | input | 1 | Column present |
| req_page | input | PAGE_W | Page address |
| req_page_vld | input | 1 | Page present |
| req_bus16 | input | 1 | Device has a 16-bit bus |
| req_big | input | 1 | Device is larger than 32 MiB |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_dq | output | 16 | Data bus out |
| nand_rdy | input | 1 | Device ready (asynchronous) |
| seq_done | output | 1 | Sequence finished, one-cycle pulse |

## Verification
The assertions assume that the host holds the request fields stable in the cycle in which the request is taken. They also assume that the column fits in COL_W bits and the page in 20 bits. The bench drives every request field at the falling edge, and it keeps `nand_rdy` low from the moment a request is offered until a chosen cycle. This makes every wait length known in advance. A timed-out read is produced by never raising ready. Reset is only ever given a ready that does rise, because its wait has no bound.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
    localparam logic [7:0] OP_READ0   = 8'h00;
    localparam logic [7:0] OP_READ1   = 8'h01;
    localparam logic [7:0] OP_READOOB = 8'h50;
    localparam logic [7:0] OP_SEQIN   = 8'h80;
    localparam logic [7:0] OP_PROG    = 8'h10;
    localparam logic [7:0] OP_ERASE1  = 8'h60;
    localparam logic [7:0] OP_ERASE2  = 8'hD0;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_RESET   = 8'hFF;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_CMD, S_ADDR, S_TWB, S_WAIT, S_DONE
    } seq_state_t;
endpackage

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_async,
    output logic rdy_s
);
    logic meta_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            rdy_s  <= 1'b0;
        end else begin
            meta_q <= rdy_async;
            rdy_s  <= meta_q;
        end
    end
endmodule

// File: rtl/nand_seq_timer.sv
module nand_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else          count <= count + 1'b1;
    end
endmodule

// File: rtl/nand_addr_plan.sv
module nand_addr_plan
    import nand_seq_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int PAGE_W     = 20,
    parameter int PAGE_BYTES = 512
) (
    input  logic [7:0]        cmd,
    input  logic [COL_W-1:0]  col,
    input  logic              col_vld,
    input  logic [PAGE_W-1:0] page,
    input  logic              page_vld,
    input  logic              bus16,
    input  logic              big,
    output logic [7:0]        pre_cmd,
    output logic [3:0][7:0]   addr_bytes,
    output logic [2:0]        addr_cnt,
    output logic [1:0]        page_first,
    output logic              rd_cmd,
    output logic              nowait
);
    logic [COL_W-1:0] c_adj;
    logic [23:0]      pg;
    int               k;

    assign pg = 24'(page);

    always_comb begin
        c_adj   = col;
        pre_cmd = OP_READ0;
        if (col >= COL_W'(PAGE_BYTES)) begin
            pre_cmd = OP_READOOB;
            c_adj   = col - COL_W'(PAGE_BYTES);
        end else if (col >= COL_W'(256)) begin
            pre_cmd = OP_READ1;
            c_adj   = col - COL_W'(256);
        end
        if (cmd != OP_SEQIN) c_adj = col;
        if (bus16) c_adj = c_adj >> 1;
    end

    always_comb begin
        addr_bytes = '0;
        k          = 0;
        if (col_vld) begin
            addr_bytes[0] = c_adj[7:0];
            k = 1;
        end
        page_first = 2'(k);
        if (page_vld) begin
            addr_bytes[k]     = pg[7:0];
            addr_bytes[k + 1] = pg[15:8];
            k = k + 2;
            if (big) begin
                addr_bytes[k] = {4'h0, pg[19:16]};
                k = k + 1;
            end
        end
        addr_cnt = 3'(k);
    end

    always_comb begin
        rd_cmd = (cmd == OP_READ0) || (cmd == OP_READ1) || (cmd == OP_READOOB);
        nowait = (cmd == OP_PROG) || (cmd == OP_ERASE1) || (cmd == OP_ERASE2) ||
                 (cmd == OP_SEQIN) || (cmd == OP_STATUS);
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int COL_W      = 10,
    parameter int PAGE_W     = 20,
    parameter int PAGE_BYTES = 512,
    parameter int WE_CYC     = 2,
    parameter int CLK_PS     = 10000,
    parameter int TWB_PS     = 100000,
    parameter int TOUT_PS    = 30000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_col_vld,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              req_page_vld,
    input  logic              req_bus16,
    input  logic              req_big,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_ce_n,
    output logic              nand_we_n,
    output logic [15:0]       nand_dq,
    input  logic              nand_rdy,
    output logic              seq_done
);
    localparam int BYTE_CYC = 2 * WE_CYC;
    localparam int TWB_CYC  = (TWB_PS + CLK_PS - 1) / CLK_PS;
    localparam int TOUT_CYC = (TOUT_PS + CLK_PS - 1) / CLK_PS;
    localparam int PH_W     = $clog2(BYTE_CYC) + 1;
    localparam int WT_W     = $clog2(TOUT_CYC + TWB_CYC + 1) + 1;

    seq_state_t        state, state_nx;
    logic [7:0]        r_cmd;
    logic [COL_W-1:0]  r_col;
    logic [PAGE_W-1:0] r_page;
    logic              r_colv, r_pagev, r_b16, r_big;
    logic [1:0]        addr_idx;
    logic              ce_force;

    logic [7:0]        pre_cmd;
    logic [3:0][7:0]   addr_bytes;
    logic [2:0]        addr_cnt;
    logic [1:0]        page_first;
    logic              plan_rd, plan_nowait;
    logic              rdy_s;
    logic [PH_W-1:0]   ph_cnt;
    logic [WT_W-1:0]   wcnt;
    logic              in_byte, byte_end, twb_end, addr_last, in_wait_span;
    seq_state_t        post_st;

    nand_addr_plan #(.COL_W(COL_W), .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES)) u_plan (
        .cmd(r_cmd), .col(r_col), .col_vld(r_colv), .page(r_page), .page_vld(r_pagev),
        .bus16(r_b16), .big(r_big), .pre_cmd(pre_cmd), .addr_bytes(addr_bytes),
        .addr_cnt(addr_cnt), .page_first(page_first), .rd_cmd(plan_rd), .nowait(plan_nowait)
    );

    nand_rdy_sync u_sync (.clk(clk), .rst_n(rst_n), .rdy_async(nand_rdy), .rdy_s(rdy_s));

    assign in_byte      = (state == S_PRE) || (state == S_CMD) || (state == S_ADDR);
    assign in_wait_span = (state == S_TWB) || (state == S_WAIT);
    assign byte_end     = in_byte && (ph_cnt == PH_W'(BYTE_CYC - 1));
    assign twb_end      = (state == S_TWB) && (wcnt == WT_W'(TWB_CYC - 1));
    assign addr_last    = ({1'b0, addr_idx} == addr_cnt - 3'd1);
    assign post_st      = plan_nowait ? S_DONE : S_TWB;

    nand_seq_timer #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(!in_byte || byte_end), .count(ph_cnt)
    );
    nand_seq_timer #(.W(WT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .clr(!in_wait_span || twb_end), .count(wcnt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (req_valid) state_nx = (req_cmd == OP_SEQIN) ? S_PRE : S_CMD;
            S_PRE:  if (byte_end) state_nx = S_CMD;
            S_CMD:  if (byte_end) state_nx = (r_colv || r_pagev) ? S_ADDR : post_st;
            S_ADDR: if (byte_end && addr_last) state_nx = post_st;
            S_TWB:  if (twb_end) state_nx = S_WAIT;
            S_WAIT: if (rdy_s || (plan_rd && wcnt == WT_W'(TOUT_CYC - 1))) state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            r_cmd    <= '0;
            r_col    <= '0;
            r_page   <= '0;
            r_colv   <= 1'b0;
            r_pagev  <= 1'b0;
            r_b16    <= 1'b0;
            r_big    <= 1'b0;
            addr_idx <= '0;
            ce_force <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && req_valid) begin
                r_cmd   <= req_cmd;
                r_col   <= req_col;
                r_page  <= req_page;
                r_colv  <= req_col_vld;
                r_pagev <= req_page_vld;
                r_b16   <= req_bus16;
                r_big   <= req_big;
            end
            if (state != S_ADDR)  addr_idx <= '0;
            else if (byte_end)    addr_idx <= addr_idx + 2'd1;
            if (state == S_ADDR && byte_end && plan_rd && r_pagev && addr_idx == page_first)
                ce_force <= 1'b1;
            else if (state == S_IDLE || (state == S_WAIT && state_nx != S_WAIT))
                ce_force <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        nand_cle  = (state == S_PRE) || (state == S_CMD);
        nand_ale  = (state == S_ADDR);
        nand_we_n = !(in_byte && ph_cnt < PH_W'(WE_CYC));
        nand_ce_n = !(in_byte || ce_force);
        seq_done  = (state == S_DONE);
        req_ready = (state == S_IDLE);
        unique case (state)
            S_PRE:   nand_dq = {8'h00, pre_cmd};
            S_CMD:   nand_dq = {8'h00, r_cmd};
            S_ADDR:  nand_dq = {8'h00, addr_bytes[addr_idx]};
            default: nand_dq = 16'h0000;
        endcase
    end

    // R2: latches never both open
    p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R7: a strobe always happens with chip enabled
    p_we_needs_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> !nand_ce_n);
    // R1: done is a single pulse and the block is idle next
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!seq_done && req_ready));
    // R11: bounded read wait never overruns its counter
    p_read_timeout_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && plan_rd) |-> (wcnt < WT_W'(TOUT_CYC)));
    // R9: ready wait always entered through the tWB delay
    p_twb_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && $past(state) != S_WAIT) |-> ($past(state) == S_TWB));
    // R4: address phase needs a present field
    p_addr_needs_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ale |-> (r_colv || r_pagev));
endmodule

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
    localparam int CLK_NS   = 10;
    localparam int WE_CYC   = 2;
    localparam int BYTE_CYC = 2 * WE_CYC;
    localparam int TWB_CYC  = 10;
    localparam int TOUT_CYC = 3000;
    localparam int NEVER    = 1000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_cmd = '0;
    logic [9:0]  req_col = '0;
    logic        req_col_vld = 1'b0;
    logic [19:0] req_page = '0;
    logic        req_page_vld = 1'b0;
    logic        req_bus16 = 1'b0;
    logic        req_big = 1'b0;
    logic        nand_cle, nand_ale, nand_ce_n, nand_we_n, seq_done;
    logic [15:0] nand_dq;
    logic        nand_rdy = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_NS / 2) clk = ~clk;

    nand_cmd_seq #(.COL_W(10), .PAGE_W(20), .PAGE_BYTES(512), .WE_CYC(WE_CYC),
                   .CLK_PS(CLK_NS * 1000), .TWB_PS(100000), .TOUT_PS(30000000)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_col(req_col), .req_col_vld(req_col_vld),
        .req_page(req_page), .req_page_vld(req_page_vld), .req_bus16(req_bus16),
        .req_big(req_big), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_dq(nand_dq),
        .nand_rdy(nand_rdy), .seq_done(seq_done)
    );

    // vector: {ready, done, ce_n, we_n, ale, cle, dq}
    function automatic logic [21:0] pack_out();
        return {req_ready, seq_done, nand_ce_n, nand_we_n, nand_ale, nand_cle, nand_dq};
    endfunction

    task automatic check(input string tag, input int cyc, input logic [21:0] act,
                         input logic [21:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d act=%h exp=%h", tag, cyc, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [7:0] cmd, input int col, input bit colv,
                       input int page, input bit pagev, input bit b16, input bit big,
                       input int rise, input bit poke);
        logic [7:0] bq[$];
        bit         isc[$];
        int c, ncmd, fp, w0, cend, dcyc, nb;
        bit rd, nowait, forced;
        logic [21:0] exp;
        rd     = (cmd == 8'h00) || (cmd == 8'h01) || (cmd == 8'h50);
        nowait = (cmd == 8'h10) || (cmd == 8'h60) || (cmd == 8'hD0) ||
                 (cmd == 8'h80) || (cmd == 8'h70);
        c = col;
        if (cmd == 8'h80) begin
            if (col >= 512)      begin bq.push_back(8'h50); c = col - 512; end
            else if (col < 256)  bq.push_back(8'h00);
            else                 begin bq.push_back(8'h01); c = col - 256; end
            isc.push_back(1);
        end
        bq.push_back(cmd); isc.push_back(1);
        ncmd = bq.size();
        if (b16) c = c / 2;
        if (colv) begin bq.push_back(c[7:0]); isc.push_back(0); end
        fp = bq.size();
        if (pagev) begin
            bq.push_back(page[7:0]);  isc.push_back(0);
            bq.push_back(page[15:8]); isc.push_back(0);
            if (big) begin bq.push_back({4'h0, page[19:16]}); isc.push_back(0); end
        end
        nb = bq.size();
        forced = rd && pagev;
        w0 = nb * BYTE_CYC + TWB_CYC;
        if (nowait) begin
            dcyc = nb * BYTE_CYC;
            cend = dcyc - 1;
        end else begin
            cend = (rise + 2 > w0) ? rise + 2 : w0;
            if (rd && cend > w0 + TOUT_CYC - 1) cend = w0 + TOUT_CYC - 1;
            dcyc = cend + 1;
        end
        @(negedge clk);
        nand_rdy = 1'b0;
        req_cmd = cmd; req_col = 10'(col); req_col_vld = colv;
        req_page = 20'(page); req_page_vld = pagev; req_bus16 = b16; req_big = big;
        req_valid = 1'b1;
        @(negedge clk);
        if (poke) req_cmd = 8'h70;
        else      req_valid = 1'b0;
        for (c = 0; c <= dcyc + 1; c++) begin
            if (c < nb * BYTE_CYC) begin
                int k;
                k = c / BYTE_CYC;
                exp = {1'b0, 1'b0, 1'b0, ((c % BYTE_CYC) >= WE_CYC), !isc[k], isc[k],
                       8'h00, bq[k]};
            end else if (c < dcyc) begin
                exp = {1'b0, 1'b0, !forced, 1'b1, 1'b0, 1'b0, 16'h0000};
            end else if (c == dcyc) begin
                exp = {1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000};
            end else begin
                exp = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000};
            end
            check(tag, c, pack_out(), exp);
            if (c == rise) nand_rdy = 1'b1;
            if (poke && c == 3) req_valid = 1'b0;
            if (c != dcyc + 1) @(negedge clk);
        end
        nand_rdy = 1'b0;
        if (ncmd == 0) $display("unreachable");
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset", 0, pack_out(), {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000});
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 after reset", 0, pack_out(), {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000});
        run("R9 R10 R11 reset cmd unbounded",       8'hFF, 0,     0, 0,       0, 0, 0, 40,    0);
        run("R2 R5 R6 R7 R10 read0 small",          8'h00, 5,     1, 'h01234, 1, 0, 0, 30,    0);
        run("R6 R7 R11 read0 big timeout",          8'h00, 7,     1, 'hABCDE, 1, 0, 1, NEVER, 0);
        run("R3 R8 seqin low column",               8'h80, 10,    1, 'h00042, 1, 0, 0, NEVER, 0);
        run("R3 seqin mid column",                  8'h80, 300,   1, 'h00100, 1, 0, 0, NEVER, 0);
        run("R3 seqin spare column",                8'h80, 520,   1, 'h00003, 1, 0, 1, NEVER, 0);
        run("R3 R5 seqin bus16",                    8'h80, 300,   1, 'h00010, 1, 1, 0, NEVER, 0);
        run("R5 R7 read1 bus16",                    8'h01, 'h1FE, 1, 'h00777, 1, 1, 0, 50,    0);
        run("R4 R6 R8 erase1 page only big",        8'h60, 0,     0, 'h5A5A5, 1, 0, 1, NEVER, 0);
        run("R4 R8 status no address",              8'h70, 0,     0, 0,       0, 0, 0, NEVER, 0);
        run("R1 R8 prog ignored request while busy", 8'h10, 0,    0, 0,       0, 0, 0, NEVER, 1);
        run("R8 erase2",                            8'hD0, 0,     0, 0,       0, 0, 0, NEVER, 0);
        run("R7 R11 readoob column only",           8'h50, 3,     1, 0,       0, 0, 0, 20,    0);
        run("R9 R11 other cmd unbounded late ready", 8'h90, 0,    1, 0,       0, 0, 0, 3500,  0);
        run("R1 back to back read",                 8'h00, 0,     1, 'h00001, 1, 0, 0, 0,     0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule